// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Controller

This block keeps two pending interrupt bits for each of up to four processors: an inter-processor interrupt (IPI) bit and an interval-timer bit. Software drives both through one wide control word. A single write can request IPIs, clear IPIs and clear timer interrupts, each in its own nibble, for any mix of CPUs. A periodic tick input, produced elsewhere by the timer divider, posts the timer interrupt to every active CPU. Both pending vectors leave the block as plain level outputs that feed the processors' interrupt inputs.

A read returns both pending vectors and the number of the CPU making the access. Redundant IPI requests and IPI clears that have nothing to clear leave the state as it is. Instead, they set sticky warning flags. A write that touches none of the recognised fields sets a sticky error flag. A parameter sets how many CPUs are present. Bits that belong to absent CPUs are never set.

Top module: `ipi_timer_intc`

## Requirements
- R1: A synchronous active-high reset clears both pending vectors and all three flags.
- R2: In a write, a 1 in bit 12+i requests an IPI for CPU i, and the IPI pending bit i is set on the following clock edge.
- R3: In a write, a 1 in bit 8+i clears the IPI pending bit for CPU i. The clear is applied after the request of the same write, so requesting and clearing one CPU in a single write leaves its bit 0.
- R4: A request for a CPU whose IPI bit is already pending leaves that bit set and sets the sticky flag warn_dup.
- R5: A clear for a CPU that has no IPI pending and no request in the same write sets the sticky flag warn_spur and changes no state.
- R6: A cycle with tick high sets the timer pending bit of every active CPU.
- R7: In a write, a 1 in bit 4+i clears the timer pending bit of CPU i. When a tick arrives in the same cycle, the clear wins.
- R8: CPUs numbered ACTIVE_CPUS and above are never made pending and never raise a flag, whatever the write or tick.
- R9: A write whose only set bit among bits [28] and [15:4] is bit 28 is accepted. It changes no pending bit and sets no flag.
- R10: A write with bits [15:4] all zero and bit 28 clear sets the sticky flag err_unsup and changes no pending bit.
- R11: rd_data holds the IPI vector at bits [11:8], the timer vector at bits [7:4] and rd_cpu at bits [1:0]. All other bits are zero.
- R12: With no write and no tick, both pending vectors hold their values. Flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Interval-timer tick, one cycle per period |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | DATA_W | Control word being written |
| rd_cpu | input | 2 | Number of the CPU making the read |
| rd_data | output | DATA_W | Read value of the control word |
| ipi_pend | output | 4 | IPI pending, one bit per CPU |
| tmr_pend | output | 4 | Timer interrupt pending, one bit per CPU |
| warn_dup | output | 1 | Sticky: an IPI was requested while already pending |
| warn_spur | output | 1 | Sticky: an IPI was cleared while none was pending |
| err_unsup | output | 1 | Sticky: a write held no recognised field |

## Verification
The bench aims at these corner cases:
- A request and a clear for the same CPU in one write. A controller that applied the clear first would leave the IPI stuck pending.
- A tick together with a timer clear. Letting the tick win would re-raise an interrupt that software has just acknowledged.
- Writes and ticks that touch the absent fourth CPU, with three CPUs configured. A missing mask would make a phantom interrupt pending.
- Writes carrying only bit 28, and writes carrying no recognised field at all. These separate the accepted-but-inert case from the error case.
- A clear issued against an empty CPU in the same write as a request. Treating it as spurious would give a false warning.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int CPU_MAX    = 4;
   localparam int CPU_ID_W   = $clog2(CPU_MAX);
   localparam int REQ_LSB    = 12;
   localparam int CLR_LSB    = 8;
   localparam int TCLR_LSB   = 4;
   localparam int ACK_BIT    = 28;
   localparam int RD_IPI_LSB = 8;
   localparam int RD_TMR_LSB = 4;
   localparam int MIN_DATA_W = ACK_BIT + 1;

   typedef logic [CPU_MAX-1:0] cpu_vec_t;

   typedef struct packed {
      cpu_vec_t req;
      cpu_vec_t clr;
      cpu_vec_t tclr;
      logic     recog;
   } intc_cmd_t;

   function automatic cpu_vec_t active_mask(input int n);
      cpu_vec_t m;
      for (int i = 0; i < CPU_MAX; i++) m[i] = (i < n);
      return m;
   endfunction
endpackage

// File: rtl/intc_wr_decode.sv
module intc_wr_decode
   import intc_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int ACTIVE_CPUS = 4
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output intc_cmd_t         cmd
);
   localparam cpu_vec_t ACT = active_mask(ACTIVE_CPUS);

   cpu_vec_t req_raw, clr_raw, tclr_raw;
   logic     unused_bits;

   assign req_raw  = wr_data[REQ_LSB  +: CPU_MAX];
   assign clr_raw  = wr_data[CLR_LSB  +: CPU_MAX];
   assign tclr_raw = wr_data[TCLR_LSB +: CPU_MAX];
   assign unused_bits = ^{wr_data[DATA_W-1:ACK_BIT+1], wr_data[ACK_BIT-1:REQ_LSB+CPU_MAX],
                          wr_data[TCLR_LSB-1:0]};

   for (genvar i = 0; i < CPU_MAX; i++) begin : g_cpu
      if (i < ACTIVE_CPUS) begin : g_on
         assign cmd.req[i]  = wr_en & req_raw[i];
         assign cmd.clr[i]  = wr_en & clr_raw[i];
         assign cmd.tclr[i] = wr_en & tclr_raw[i];
      end else begin : g_off
         assign cmd.req[i]  = 1'b0;
         assign cmd.clr[i]  = 1'b0;
         assign cmd.tclr[i] = 1'b0;
      end
   end

   assign cmd.recog = (|req_raw) | (|clr_raw) | (|tclr_raw) | wr_data[ACK_BIT] | (ACT == '0);
endmodule

// File: rtl/intc_ipi_bank.sv
module intc_ipi_bank
   import intc_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  cpu_vec_t req,
   input  cpu_vec_t clr,
   output cpu_vec_t pend,
   output logic     dup_hit,
   output logic     spur_hit
);
   cpu_vec_t dup_v, spur_v;

   for (genvar i = 0; i < CPU_MAX; i++) begin : g_cpu
      always_ff @(posedge clk) begin
         if (rst) pend[i] <= 1'b0;
         else if (clr[i]) pend[i] <= 1'b0;
         else if (req[i]) pend[i] <= 1'b1;
      end
      assign dup_v[i]  = req[i] & pend[i];
      assign spur_v[i] = clr[i] & ~pend[i] & ~req[i];
   end

   assign dup_hit  = |dup_v;
   assign spur_hit = |spur_v;
endmodule

// File: rtl/intc_tmr_bank.sv
module intc_tmr_bank
   import intc_pkg::*;
#(
   parameter int ACTIVE_CPUS = 4
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     tick,
   input  cpu_vec_t tclr,
   output cpu_vec_t pend
);
   for (genvar i = 0; i < CPU_MAX; i++) begin : g_cpu
      if (i < ACTIVE_CPUS) begin : g_on
         always_ff @(posedge clk) begin
            if (rst) pend[i] <= 1'b0;
            else if (tclr[i]) pend[i] <= 1'b0;
            else if (tick) pend[i] <= 1'b1;
         end
      end else begin : g_off
         logic unused_clr;
         assign unused_clr = tclr[i];
         assign pend[i] = 1'b0;
      end
   end
endmodule

// File: rtl/intc_rd_fmt.sv
module intc_rd_fmt
   import intc_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  cpu_vec_t            ipi,
   input  cpu_vec_t            tmr,
   input  logic [CPU_ID_W-1:0] cpu,
   output logic [DATA_W-1:0]   rd_data
);
   always_comb begin
      rd_data = '0;
      rd_data[RD_IPI_LSB +: CPU_MAX] = ipi;
      rd_data[RD_TMR_LSB +: CPU_MAX] = tmr;
      rd_data[CPU_ID_W-1:0]          = cpu;
   end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
   import intc_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int ACTIVE_CPUS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_cpu,
   output logic [DATA_W-1:0] rd_data,
   output logic [3:0]        ipi_pend,
   output logic [3:0]        tmr_pend,
   output logic              warn_dup,
   output logic              warn_spur,
   output logic              err_unsup
);
   if (ACTIVE_CPUS < 1 || ACTIVE_CPUS > CPU_MAX) begin : g_bad_cpus
      $error("ipi_timer_intc: ACTIVE_CPUS must lie in 1..4");
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("ipi_timer_intc: DATA_W too narrow for the control fields");
   end

   intc_cmd_t cmd;
   logic      dup_hit, spur_hit;

   intc_wr_decode #(.DATA_W(DATA_W), .ACTIVE_CPUS(ACTIVE_CPUS)) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cmd     (cmd)
   );

   intc_ipi_bank u_ipi (
      .clk      (clk),
      .rst      (rst),
      .req      (cmd.req),
      .clr      (cmd.clr),
      .pend     (ipi_pend),
      .dup_hit  (dup_hit),
      .spur_hit (spur_hit)
   );

   intc_tmr_bank #(.ACTIVE_CPUS(ACTIVE_CPUS)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .tclr (cmd.tclr),
      .pend (tmr_pend)
   );

   intc_rd_fmt #(.DATA_W(DATA_W)) u_rd (
      .ipi     (ipi_pend),
      .tmr     (tmr_pend),
      .cpu     (rd_cpu),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         warn_dup  <= 1'b0;
         warn_spur <= 1'b0;
         err_unsup <= 1'b0;
      end else begin
         warn_dup  <= warn_dup  | dup_hit;
         warn_spur <= warn_spur | spur_hit;
         err_unsup <= err_unsup | (wr_en & ~cmd.recog);
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int DATA_W      = 64,
   parameter int ACTIVE_CPUS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [1:0]        rd_cpu,
   input logic [DATA_W-1:0] rd_data,
   input logic [3:0]        ipi_pend,
   input logic [3:0]        tmr_pend,
   input logic              warn_dup,
   input logic              warn_spur,
   input logic              err_unsup
);
   localparam logic [3:0] ACT = 4'((1 << ACTIVE_CPUS) - 1);

   a_r2_req_sets: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((ipi_pend & $past(wr_data[15:12] & ~wr_data[11:8] & ACT))
                 == $past(wr_data[15:12] & ~wr_data[11:8] & ACT)));

   a_r3_clr_clears: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((ipi_pend & $past(wr_data[11:8])) == 4'b0));

   a_r4_dup_flag: assert property (@(posedge clk) disable iff (rst)
      (wr_en && |(wr_data[15:12] & ipi_pend & ACT)) |=> warn_dup);

   a_r6_tick_posts: assert property (@(posedge clk) disable iff (rst)
      (tick && !wr_en) |=> (tmr_pend == ACT));

   a_r7_tclr_wins: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((tmr_pend & $past(wr_data[7:4])) == 4'b0));

   a_r8_inactive_idle: assert property (@(posedge clk) disable iff (rst)
      ((ipi_pend | tmr_pend) & ~ACT) == 4'b0);

   a_r10_unsup_flag: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[15:4] == 12'b0 && !wr_data[28]) |=> err_unsup);

   a_r11_rd_layout: assert property (@(posedge clk) disable iff (rst)
      (rd_data[11:8] == ipi_pend) && (rd_data[7:4] == tmr_pend) && (rd_data[1:0] == rd_cpu));

   a_r12_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !tick) |=> ($stable(ipi_pend) && $stable(tmr_pend)));

   a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
      (warn_dup || warn_spur || err_unsup) |=>
      ((warn_dup >= $past(warn_dup)) && (warn_spur >= $past(warn_spur))
       && (err_unsup >= $past(err_unsup))));
endmodule

bind ipi_timer_intc intc_chk #(.DATA_W(DATA_W), .ACTIVE_CPUS(ACTIVE_CPUS)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
   .rd_cpu(rd_cpu), .rd_data(rd_data), .ipi_pend(ipi_pend), .tmr_pend(tmr_pend),
   .warn_dup(warn_dup), .warn_spur(warn_spur), .err_unsup(err_unsup)
);

// File: tb/ipi_timer_intc_bench.sv
module ipi_timer_intc_bench;
   localparam int DW  = 64;
   localparam int NA  = 3;
   localparam logic [3:0] ACT = 4'b0111;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_cpu = 2'd0;
   logic [DW-1:0] rd_data;
   logic [3:0]    ipi_pend, tmr_pend;
   logic          warn_dup, warn_spur, err_unsup;

   int checks = 0;
   int fails  = 0;

   logic [3:0] m_ipi = '0, m_tmr = '0;
   logic       m_dup = 0, m_spur = 0, m_unsup = 0;

   always #10 clk = ~clk;

   ipi_timer_intc #(.DATA_W(DW), .ACTIVE_CPUS(NA)) u_ipi_timer_intc (
      .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
      .rd_cpu(rd_cpu), .rd_data(rd_data), .ipi_pend(ipi_pend), .tmr_pend(tmr_pend),
      .warn_dup(warn_dup), .warn_spur(warn_spur), .err_unsup(err_unsup)
   );

   function automatic logic [DW-1:0] exp_rd(input logic [3:0] ip, input logic [3:0] tm,
                                            input logic [1:0] c);
      return (DW'(ip) << 8) | (DW'(tm) << 4) | DW'(c);
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R2/R3 ipi_pend"}, DW'(ipi_pend), DW'(m_ipi));
      chk({tag, " R6/R7 tmr_pend"}, DW'(tmr_pend), DW'(m_tmr));
      chk({tag, " R4 warn_dup"}, DW'(warn_dup), DW'(m_dup));
      chk({tag, " R5 warn_spur"}, DW'(warn_spur), DW'(m_spur));
      chk({tag, " R10 err_unsup"}, DW'(err_unsup), DW'(m_unsup));
      chk({tag, " R11 rd_data"}, rd_data, exp_rd(m_ipi, m_tmr, rd_cpu));
   endtask

   task automatic model(input logic w, input logic [DW-1:0] d, input logic t);
      logic [3:0] req, clr, tclr;
      req  = w ? d[15:12] & ACT : 4'b0;
      clr  = w ? d[11:8]  & ACT : 4'b0;
      tclr = w ? d[7:4]   & ACT : 4'b0;
      m_dup   = m_dup   | (|(req & m_ipi));
      m_spur  = m_spur  | (|(clr & ~(m_ipi | req)));
      m_unsup = m_unsup | (w && d[15:4] == 12'b0 && !d[28]);
      m_ipi   = (m_ipi | req) & ~clr;
      m_tmr   = (m_tmr | (t ? ACT : 4'b0)) & ~tclr;
   endtask

   task automatic step(input string tag, input logic w, input logic [DW-1:0] d,
                       input logic t, input logic [1:0] c);
      @(negedge clk);
      wr_en = w; wr_data = d; tick = t; rd_cpu = c;
      @(posedge clk);
      #2;
      wr_en = 1'b0; tick = 1'b0;
      model(w, d, t);
      #3;
      check_all(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      rst = 1'b0;
      m_ipi = '0; m_tmr = '0; m_dup = 0; m_spur = 0; m_unsup = 0;
      #3;
      check_all("R1 reset");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (2) @(posedge clk);
      do_reset();
      // R2: request IPIs to CPU0 and CPU2
      step("R2 req", 1, 64'h0000_5000, 0, 2'd1);
      // R4: duplicate request to CPU0
      step("R4 dup", 1, 64'h0000_1000, 0, 2'd2);
      // R3: request and clear CPU1 in one write, clear CPU0
      step("R3 req+clr", 1, 64'h0000_2300, 0, 2'd0);
      // R5: clear a CPU with nothing pending
      step("R5 spur", 1, 64'h0000_0200, 0, 2'd3);
      // R8: request and tick aimed at absent CPU3
      step("R8 absent cpu", 1, 64'h0000_8800, 1, 2'd3);
      // R6: bare tick
      step("R6 tick", 0, 64'h0, 1, 2'd1);
      // R7: clear with a tick in the same cycle
      step("R7 clr vs tick", 1, 64'h0000_0050, 1, 2'd2);
      // R12: idle cycles keep state
      step("R12 idle", 0, 64'h0, 0, 2'd0);
      step("R12 idle", 0, 64'h0, 0, 2'd3);
      do_reset();
      // R9: bit 28 only, plus unrelated bits
      step("R9 ack only", 1, 64'h8000_0000_1000_000F, 0, 2'd1);
      // R10: no recognised field
      step("R10 unsup", 1, 64'hFFFF_0000_0FFF_000F, 0, 2'd2);
      step("R12 sticky", 0, 64'h0, 0, 2'd0);
      do_reset();
      for (int k = 0; k < 600; k++) begin
         logic [DW-1:0] d;
         logic [31:0] r;
         d = {$urandom, $urandom};
         r = $urandom;
         if (r[1:0] == 2'd0) d[31:0] = d[31:0] & 32'h0000_F000;
         if (r[3:2] == 2'd0) d[15:4] = 12'h0;
         if (r[5:4] == 2'd0) d = d & 64'h0000_0000_0000_FFF0;
         step("R2-rand", r[6] | r[7], d, r[8] & r[9], r[11:10]);
         if (r[15:12] == 4'd0) do_reset();
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule